// File: doc/BRIEF.md
# Load-use interlock for a five-stage pipeline decoder

This block sits beside the decode stage of an in-order five-stage pipeline. Each cycle it looks at the instruction being decoded and at the instruction held in the decode/execute register. If that older instruction is a load whose target register is a source the younger one needs at once, forwarding cannot supply the value in time. The block then freezes the program counter and the fetch/decode register, so the same instruction is decoded again next cycle. It also asks the pipeline to load a no-op into the control fields of decode/execute.

Two instructions further back, the loaded value already reaches the execute inputs and the data memory input by forwarding. So the freeze lasts one cycle. The block keeps one bit of history, so it never stalls twice in a row, even if the decode/execute opcode field still shows the load after its controls were cleared. The decisions are combinational in the cycle the hazard is visible; only the history bit is clocked.

Top module: `load_use_interlock`

## Requirements
- R1: During and right after reset, with no hazard presented, `pc_we` and `ifid_we` are 1 and `idex_bubble` is 0. The first qualifying hazard after reset stalls.
- R2: When `ex_opcode` is the load code 0x23, `ex_rt` is nonzero, and a decoded load (0x23) has `id_rs == ex_rt`, then in that same cycle `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1.
- R3: A decoded register-register instruction (opcode 0x00) reads both `id_rs` and `id_rt`. A match of either against a load's nonzero `ex_rt` stalls.
- R4: A decoded store (0x2B) stalls on an `id_rs` (address base) match. An `id_rt` (store data) match alone does not stall.
- R5: A decoded register-immediate instruction (opcodes 0x08 to 0x0F) stalls on an `id_rs` match only. Its `id_rt` is a destination, and a match there does not stall.
- R6: A decoded zero-test branch (0x04) stalls on an `id_rs` match.
- R7: A load whose `ex_rt` is 0 never causes a stall.
- R8: When `ex_opcode` is register-register, register-immediate, store or branch, no stall occurs for any register match.
- R9: A stall lasts exactly one cycle. In the cycle after a stall there is no stall, even if the inputs are unchanged. The cycle after that may stall again.
- R10: When no source the decoded instruction reads matches `ex_rt`, no stall occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the history bit |
| id_opcode | input | 6 | Opcode of the instruction in decode |
| id_rs | input | 5 | First source field of the instruction in decode |
| id_rt | input | 5 | Second field of the instruction in decode |
| ex_opcode | input | 6 | Opcode held in decode/execute |
| ex_rt | input | 5 | Load target field held in decode/execute |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Select no-op for decode/execute control fields |

## Verification
A stuck or lost history bit shows at the ports within one cycle of a stall. If it is stuck at one, the enables fail to drop on a real hazard. If it is never set, the enables stay low for two cycles when the inputs are held. A wrong source-use decode shows only for the opcode and field pair it covers, so every opcode class is checked against a match on each field in turn. A producer or zero-register qualifier error shows as a spurious bubble in the cycle the inputs are applied.

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int OP_W = 6,
  parameter int REG_W = 5,
  parameter logic [OP_W-1:0] OP_RR = 6'h00,
  parameter logic [OP_W-1:0] OP_LOAD = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE = 6'h2B,
  parameter logic [OP_W-1:0] OP_BRZ = 6'h04,
  parameter logic [OP_W-1:0] OP_IALU_LO = 6'h08,
  parameter logic [OP_W-1:0] OP_IALU_HI = 6'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  id_opcode,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [OP_W-1:0]  ex_opcode,
  input  logic [REG_W-1:0] ex_rt,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             idex_bubble
);

  logic id_rr, id_ialu, id_reads_rs, id_reads_rt;
  logic ex_loads, rs_hit, rt_hit, stall, stalled_q;

  assign id_rr       = (id_opcode == OP_RR);
  assign id_ialu     = (id_opcode >= OP_IALU_LO) && (id_opcode <= OP_IALU_HI);
  assign id_reads_rs = id_rr || id_ialu || (id_opcode == OP_LOAD) ||
                       (id_opcode == OP_STORE) || (id_opcode == OP_BRZ);
  assign id_reads_rt = id_rr;

  assign ex_loads = (ex_opcode == OP_LOAD) && (ex_rt != '0);
  assign rs_hit   = id_reads_rs && (id_rs == ex_rt);
  assign rt_hit   = id_reads_rt && (id_rt == ex_rt);
  assign stall    = !stalled_q && ex_loads && (rs_hit || rt_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= stall;
  end

  assign pc_we       = !stall;
  assign ifid_we     = !stall;
  assign idex_bubble = stall;

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> !idex_bubble);

  assert_load_producer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (ex_opcode == OP_LOAD));

  assert_zero_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (ex_rt != '0));

  assert_field_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> ((id_rs == ex_rt) || (id_rt == ex_rt)));

  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_we && !ifid_we));

endmodule

// File: tb/tb_load_use_interlock.sv
module tb_load_use_interlock;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] id_opcode = 6'h3F, ex_opcode = 6'h3F;
  logic [4:0] id_rs = '0, id_rt = '0, ex_rt = '0;
  logic pc_we, ifid_we, idex_bubble;

  typedef struct { logic st; string tag; } exp_t;
  exp_t sb[$];
  int total = 0, bad = 0;
  logic prev_st = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  load_use_interlock dut (.clk(clk), .rst_n(rst_n), .id_opcode(id_opcode),
    .id_rs(id_rs), .id_rt(id_rt), .ex_opcode(ex_opcode), .ex_rt(ex_rt),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble));

  function automatic logic model(input logic [5:0] iop, input logic [4:0] rs,
      input logic [4:0] rt, input logic [5:0] eop, input logic [4:0] ert);
    logic rr, rds, rdt;
    rr  = (iop == 6'h00);
    rds = rr || (iop >= 6'h08 && iop <= 6'h0F) || iop == 6'h23 || iop == 6'h2B || iop == 6'h04;
    rdt = rr;
    return (eop == 6'h23) && (ert != 0) && ((rds && rs == ert) || (rdt && rt == ert));
  endfunction

  task automatic drive(input logic [5:0] iop, input logic [4:0] rs, input logic [4:0] rt,
      input logic [5:0] eop, input logic [4:0] ert, input string tag);
    exp_t e;
    @(negedge clk);
    id_opcode = iop; id_rs = rs; id_rt = rt; ex_opcode = eop; ex_rt = ert;
    e.st = rst_n && !prev_st && model(iop, rs, rt, eop, ert);
    e.tag = tag;
    if (!rst_n) e.st = 1'b0 || (!prev_st && model(iop, rs, rt, eop, ert));
    prev_st = rst_n ? e.st : 1'b0;
    sb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (pc_we !== !e.st || ifid_we !== !e.st || idex_bubble !== e.st) begin
          bad++;
          $display("FAIL %s: pc_we=%b ifid_we=%b bubble=%b expected stall=%b",
                   e.tag, pc_we, ifid_we, idex_bubble, e.st);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    drive(6'h3F, 0, 0, 6'h3F, 0, "R1 in reset");
    drive(6'h00, 1, 2, 6'h00, 3, "R1 in reset no hazard");
    @(negedge clk); rst_n = 1'b1;
    drive(6'h00, 1, 2, 6'h00, 3, "R1 after reset idle");
    drive(6'h23, 7, 9, 6'h23, 7, "R1 R2 first hazard load rs");
    drive(6'h00, 1, 2, 6'h00, 3, "R10 filler");
    drive(6'h00, 4, 5, 6'h23, 4, "R3 rr rs match");
    drive(6'h00, 1, 2, 6'h00, 3, "R10 filler");
    drive(6'h00, 4, 5, 6'h23, 5, "R3 rr rt match");
    drive(6'h00, 1, 2, 6'h00, 3, "R10 filler");
    drive(6'h2B, 6, 8, 6'h23, 6, "R4 store base match");
    drive(6'h00, 1, 2, 6'h00, 3, "R10 filler");
    drive(6'h2B, 6, 8, 6'h23, 8, "R4 store data no stall");
    drive(6'h0C, 10, 11, 6'h23, 10, "R5 ialu rs match");
    drive(6'h00, 1, 2, 6'h00, 3, "R10 filler");
    drive(6'h08, 10, 11, 6'h23, 11, "R5 ialu rt no stall");
    drive(6'h0F, 12, 13, 6'h23, 13, "R5 ialu high code rt no stall");
    drive(6'h04, 14, 0, 6'h23, 14, "R6 branch rs match");
    drive(6'h00, 1, 2, 6'h00, 3, "R10 filler");
    drive(6'h00, 0, 0, 6'h23, 0, "R7 zero dest rr");
    drive(6'h23, 0, 3, 6'h23, 0, "R7 zero dest load");
    drive(6'h00, 9, 9, 6'h00, 9, "R8 rr producer");
    drive(6'h00, 9, 9, 6'h0A, 9, "R8 ialu producer");
    drive(6'h00, 9, 9, 6'h2B, 9, "R8 store producer");
    drive(6'h00, 9, 9, 6'h04, 9, "R8 branch producer");
    drive(6'h00, 20, 21, 6'h23, 20, "R9 stall held one");
    drive(6'h00, 20, 21, 6'h23, 20, "R9 repeat no stall");
    drive(6'h00, 20, 21, 6'h23, 20, "R9 stalls again");
    drive(6'h00, 1, 2, 6'h23, 3, "R10 load no match");
    drive(6'h3E, 3, 3, 6'h23, 3, "R10 unknown op reads nothing");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule